// File: doc/BRIEF.md
# Keypad Event Queue with Indexed Peek

This block stores key events reported by a keypad scanner in a small circular buffer and hands them to a register-access front end. Each event is one byte: a key code plus a bit telling whether the key went down or came up. The front end can read events in two ways. A consuming read advances the queue. A peek returns the entry at a chosen distance from the head and leaves the queue unchanged.

The head index points at the slot that was consumed last, not at the next unread slot. The head entry therefore stays visible to a peek at offset zero. A consuming read never releases the last stored slot.

The block gives the interrupt/status unit a one-cycle pulse for each accepted event. It also gives that unit a one-cycle pulse and a sticky pending flag when an event is lost. The sticky flag shuts the input until the status unit clears it. A flush input, raised when configuration is written, empties the queue.

Top module: `key_evt_fifo`

## Requirements
- R1: The queue holds 2^IDX_W entries (16 by default). The head and the write position wrap modulo that depth, and entries keep their order across the wrap.
- R2: A stored entry is {push_press, push_code}: the code sits in bits 6:0 and the press flag in bit 7. Reads return it in that layout.
- R3: A push is discarded when the queue already holds the full depth after any same-cycle read has been applied. Such a push raises ovf_set for that cycle, and ovf_pend is 1 from the next cycle onward.
- R4: While ovf_pend is 1, pushes are ignored: no storage, no length change, no key_evt and no ovf_set. ovf_clr or flush drops ovf_pend to 0 on the next cycle.
- R5: When pop_req is high and fifo_len is 2 or more, pop_data in the same cycle is the entry at head+1. On the next edge the head moves forward by one and the length falls by one. When fifo_len is 0 or 1, pop_data is 0x00 and the read changes nothing.
- R6: peek_data is the entry at (head + peek_off) mod depth when peek_off < fifo_len, and 0x00 otherwise. A peek never changes any state.
- R7: key_evt is high for exactly the cycles in which a push is stored.
- R8: When flush is high, the next cycle shows fifo_len = 0 and a head of zero. Any push or read in the flush cycle is ignored, and pop_data, key_evt and ovf_set are 0 in that cycle.
- R9: A push and a read in the same cycle apply the read first. The push is then stored at head + length after the read, so a full queue accepts it.
- R10: A synchronous active-high reset clears the head, the length and ovf_pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue (configuration write) |
| push_valid | input | 1 | Scanner offers an event this cycle |
| push_code | input | CODE_W | Key code of the offered event |
| push_press | input | 1 | 1 = key pressed, 0 = released |
| pop_req | input | 1 | Consuming read this cycle |
| pop_data | output | CODE_W+1 | Byte returned by the consuming read |
| peek_off | input | OFF_W | Offset from the head for a peek |
| peek_data | output | CODE_W+1 | Byte at head plus offset, or zero |
| fifo_len | output | IDX_W+1 | Number of stored entries |
| key_evt | output | 1 | Pulse: an event was stored |
| ovf_set | output | 1 | Pulse: an event was lost to a full queue |
| ovf_clr | input | 1 | Status unit clears the pending overflow |
| ovf_pend | output | 1 | Overflow pending; pushes are shut out |

## Verification
The bench builds the block with its default parameters: a 16-entry queue, 7-bit codes and an 8-bit peek offset. With this size the whole queue can be filled and overrun within a handful of cycles. After each change of state, the bench sweeps the peek offset over every slot and past the length. A long pseudo-random run of mixed pushes, reads, flushes and overflow clears moves the head through every wrap position. It also covers simultaneous push and read at the empty, single-entry and full boundaries.

// File: rtl/key_evt_fifo.sv
module key_evt_fifo #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 7,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [CODE_W-1:0] push_code,
  input  logic              push_press,
  input  logic              pop_req,
  output logic [CODE_W:0]   pop_data,
  input  logic [OFF_W-1:0]  peek_off,
  output logic [CODE_W:0]   peek_data,
  output logic [IDX_W:0]    fifo_len,
  output logic              key_evt,
  output logic              ovf_set,
  input  logic              ovf_clr,
  output logic              ovf_pend
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = CODE_W + 1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] head_q;
  logic [IDX_W:0]   len_q;
  logic             pend_q;

  logic             rd_ok;
  logic [IDX_W-1:0] head_a;
  logic [IDX_W:0]   len_a;
  logic             room;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] peek_idx;
  logic             peek_hit;

  assign rd_ok    = pop_req && !flush && (len_q > (IDX_W+1)'(1));
  assign head_a   = head_q + IDX_W'(rd_ok);
  assign len_a    = len_q - (IDX_W+1)'(rd_ok);
  assign room     = len_a < (IDX_W+1)'(DEPTH);
  assign wr_idx   = head_a + len_a[IDX_W-1:0];

  assign key_evt  = push_valid && !flush && !pend_q && room;
  assign ovf_set  = push_valid && !flush && !pend_q && !room;

  assign pop_data = rd_ok ? mem[head_q + IDX_W'(1)] : '0;

  assign peek_hit  = 32'(peek_off) < 32'(len_q);
  assign peek_idx  = head_q + peek_off[IDX_W-1:0];
  assign peek_data = peek_hit ? mem[peek_idx] : '0;

  assign fifo_len = len_q;
  assign ovf_pend = pend_q;

  always_ff @(posedge clk) begin
    if (key_evt) mem[wr_idx] <= {push_press, push_code};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      len_q  <= '0;
    end else begin
      head_q <= head_a;
      len_q  <= len_a + (IDX_W+1)'(key_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush || ovf_clr) pend_q <= 1'b0;
    else if (ovf_set)            pend_q <= 1'b1;
  end

  AST_LEN_MAX: assert property (@(posedge clk) disable iff (rst)
    fifo_len <= (IDX_W+1)'(DEPTH)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_set && !ovf_clr |=> ovf_pend); // R3
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    ovf_pend && !ovf_clr && !flush |=> ovf_pend); // R4
  AST_PEND_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    ovf_pend |=> fifo_len <= $past(fifo_len)); // R4
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    pop_req && !flush && fifo_len > 1 && !push_valid |=> fifo_len == $past(fifo_len) - 1); // R5
  AST_POP_REFUSE: assert property (@(posedge clk) disable iff (rst)
    pop_req && fifo_len <= 1 && !push_valid && !flush |=> $stable(fifo_len)); // R5
  AST_EVT_GROW: assert property (@(posedge clk) disable iff (rst)
    key_evt && !pop_req |=> fifo_len == $past(fifo_len) + 1); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> fifo_len == '0); // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush |-> !key_evt && !ovf_set && pop_data == '0); // R8
  AST_EVT_OVF_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(key_evt && ovf_set)); // R9
endmodule

// File: tb/key_evt_fifo_tb_top.sv
`timescale 1ns/1ps
module key_evt_fifo_tb_top;
  localparam int IDX_W = 4, CODE_W = 7, OFF_W = 8, DEPTH = 16;

  logic clk = 0, rst = 1, flush = 0, push_valid = 0, push_press = 0, pop_req = 0, ovf_clr = 0;
  logic [CODE_W-1:0] push_code = '0;
  logic [OFF_W-1:0]  peek_off = '0;
  logic [CODE_W:0]   pop_data, peek_data;
  logic [IDX_W:0]    fifo_len;
  logic              key_evt, ovf_set, ovf_pend;

  always #2.5 clk = ~clk;

  key_evt_fifo #(.IDX_W(IDX_W), .CODE_W(CODE_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid), .push_code(push_code),
    .push_press(push_press), .pop_req(pop_req), .pop_data(pop_data), .peek_off(peek_off),
    .peek_data(peek_data), .fifo_len(fifo_len), .key_evt(key_evt), .ovf_set(ovf_set),
    .ovf_clr(ovf_clr), .ovf_pend(ovf_pend));

  int checks = 0, failures = 0;
  logic [7:0] m_mem [DEPTH];
  int m_head = 0, m_len = 0;
  bit m_pend = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sweep_peek();
    for (int o = 0; o < DEPTH + 3; o++) begin
      peek_off = 8'(o);
      #0.1;
      chk("R6", int'(peek_data), (o < m_len) ? int'(m_mem[(m_head + o) % DEPTH]) : 0);
    end
    peek_off = 8'd255;
    #0.1;
    chk("R6", int'(peek_data), 0);
  endtask

  task automatic step(input bit pv, input int code, input bit pr, input bit pop,
                      input bit fl, input bit clr, input int off);
    bit rd, room, acc, ovf;
    int ha, la;
    @(negedge clk);
    push_valid = pv; push_code = 7'(code); push_press = pr; pop_req = pop;
    flush = fl; ovf_clr = clr; peek_off = 8'(off);
    #1;
    chk("R1", int'(fifo_len), m_len);
    chk("R4", int'(ovf_pend), int'(m_pend));
    chk("R6", int'(peek_data), (off < m_len) ? int'(m_mem[(m_head + off) % DEPTH]) : 0);
    rd   = pop && !fl && m_len > 1;
    ha   = (m_head + (rd ? 1 : 0)) % DEPTH;
    la   = m_len - (rd ? 1 : 0);
    room = la < DEPTH;
    acc  = pv && !fl && !m_pend && room;
    ovf  = pv && !fl && !m_pend && !room;
    chk("R5", int'(pop_data), rd ? int'(m_mem[(m_head + 1) % DEPTH]) : 0);
    chk("R7", int'(key_evt), int'(acc));
    chk("R3", int'(ovf_set), int'(ovf));
    @(posedge clk);
    if (fl) begin
      m_head = 0; m_len = 0; m_pend = 0;
    end else begin
      if (acc) m_mem[(ha + la) % DEPTH] = {pr, 7'(code)};
      m_head = ha;
      m_len  = la + (acc ? 1 : 0);
      if (clr) m_pend = 0;
      else if (ovf) m_pend = 1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    push_valid = 0; pop_req = 0; flush = 0; ovf_clr = 0;
    #1;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R10", int'(fifo_len), 0);
    chk("R10", int'(ovf_pend), 0);
    chk("R5", int'(pop_data), 0);
    sweep_peek();
    // R5: single stored entry cannot be consumed
    step(1, 7'h3C, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    idle(); chk("R5", int'(fifo_len), 1); sweep_peek();
    // R2, R1: fill to full
    for (int i = 1; i < DEPTH; i++) step(1, 7'(i * 5 + 1), i[0], 0, 0, 0, i);
    idle(); chk("R1", int'(fifo_len), DEPTH); sweep_peek();
    chk("R2", int'(peek_data), 0);
    peek_off = 8'd3; #0.1;
    chk("R2", int'(peek_data), {1'b1, 7'(3 * 5 + 1)});
    // R3, R4: overflow then ignored pushes
    step(1, 7'h11, 0, 0, 0, 0, 0);
    step(1, 7'h12, 1, 0, 0, 0, 0);
    step(1, 7'h13, 1, 1, 0, 0, 2);
    idle(); chk("R4", int'(ovf_pend), 1); sweep_peek();
    step(0, 0, 0, 0, 0, 1, 0);
    // R9: push and read together on a full queue
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 0, i);
    step(1, 7'h55, 0, 0, 0, 0, 0);
    step(1, 7'h56, 1, 1, 0, 0, 15);
    idle(); chk("R9", int'(fifo_len), DEPTH); sweep_peek();
    // R5: drain to one
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 0, 0, 0);
    idle(); chk("R5", int'(fifo_len), 1); sweep_peek();
    step(1, 7'h22, 0, 1, 0, 0, 1);
    // R8: flush with competing push and read, pending cleared
    step(1, 7'h01, 0, 0, 0, 0, 0);
    step(1, 7'h02, 1, 1, 1, 0, 0);
    idle(); chk("R8", int'(fifo_len), 0); sweep_peek();
    // R1: pseudo-random sweep across all wrap positions
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], int'(lfsr[11:5]), lfsr[3], lfsr[1] & ~lfsr[9],
           (lfsr[15:8] == 8'h5A), (lfsr[7:3] == 5'd7), int'(lfsr[14:10]));
      if (n % 97 == 0) sweep_peek();
    end
    // R10: reset mid-operation
    step(1, 7'h7F, 1, 0, 0, 0, 0);
    @(negedge clk); rst = 1; push_valid = 0; pop_req = 0; flush = 0; ovf_clr = 0;
    @(negedge clk); rst = 0; #1;
    m_head = 0; m_len = 0; m_pend = 0;
    chk("R10", int'(fifo_len), 0);
    chk("R10", int'(ovf_pend), 0);
    sweep_peek();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule